// File: doc/BRIEF.md
# Dual-clock FIFO with fixed-offset flags

This block is a first-in first-out buffer that carries 8-bit words from one clock domain to another. The producer side writes on its own clock with an active-low write enable. The consumer side reads on an unrelated clock with an active-low read enable. Each read loads the oldest stored word into a registered output, and an active-low output enable either drives that register onto the data bus or leaves the bus at high impedance. Depth is a power-of-two parameter and defaults to 64 words.

The block raises four active-low status flags. Full and almost-full belong to the write clock, and empty and almost-empty belong to the read clock. The almost flags sit a fixed distance of seven words from each end. Pointers pass between the domains as Gray code through two-flop synchronizers. Each side works out its occupancy from its own pointer and the synchronized copy of the other side's pointer. Because that copy lags, the flags can stay asserted a few cycles longer than strictly needed. They never claim more data or more free space than the buffer actually holds.

A single active-low reset acts asynchronously and is released synchronously inside each domain. It rewinds both pointers, sets the flags to their idle pattern and clears the output register.

Top module: `dcf_fifo`

## Requirements
- R1: While reset is low and once it is released, empty_n and aempty_n are 0, full_n and afull_n are 1, and the output register holds 8'h00.
- R2: A word is stored on a rising wr_clk edge when wr_en_n is 0 and full_n is 1. A write attempted while full_n is 0 stores nothing.
- R3: The next word is loaded into the output register on a rising rd_clk edge when rd_en_n is 0 and empty_n is 1. A read attempted while empty_n is 0 leaves the output register and the read pointer unchanged.
- R4: While rd_en_n is 1, the output register keeps its value.
- R5: Words leave in exactly the order they were accepted, including across pointer wrap-around.
- R6: Once both domains have settled, empty_n is 0 exactly when 0 words are stored. aempty_n is 0 for 0 to 7 stored words and 1 from 8 words upward.
- R7: Once settled, full_n is 0 exactly when DEPTH words are stored (64 writes from empty with no reads). afull_n is 0 for DEPTH-7 to DEPTH words, which is 57 to 64 at the default depth.
- R8: The flags are pessimistic. empty_n is never 1 with nothing stored, and full_n is never 1 with DEPTH words stored. Full implies almost-full, and empty implies almost-empty.
- R9: After a write into an empty FIFO, empty_n rises no later than the fourth rd_clk rising edge after the write edge.
- R10: With out_en_n at 1 the rd_data bus is high impedance. With out_en_n at 0 it carries the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock, unrelated to wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_data | input | DW (8) | Word to store |
| wr_en_n | input | 1 | Active-low write request |
| full_n | output | 1 | Low when DEPTH words are stored (write domain) |
| afull_n | output | 1 | Low when at least DEPTH-7 words are stored (write domain) |
| rd_en_n | input | 1 | Active-low read request |
| out_en_n | input | 1 | Active-low output enable for rd_data |
| rd_data | output | DW (8) | Output register contents, or high impedance |
| empty_n | output | 1 | Low when no word is stored (read domain) |
| aempty_n | output | 1 | Low when 7 or fewer words are stored (read domain) |

## Verification
A corrupted pointer or Gray-code bit first shows up at rd_data as a skipped, repeated or reordered word. That happens at the first read touching the damaged location, or at the latest after one full pointer wrap of DEPTH reads, so long interleaved streams under both backpressure and starvation are compared word by word against a queue model. A wrong occupancy calculation shows up as a flag in the wrong state at one of the threshold counts 7, 8, 56, 57, 63 or 64. These are sampled after both domains have had several cycles to settle. A synchronizer that is too slow or that skips a stage changes how many rd_clk edges empty_n takes to rise after the first write. A flag that is optimistic rather than pessimistic lets a read through with nothing stored or a write through with the FIFO full, and this surfaces at once as a wrong word.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Widest pointer the conversion helpers accept (wrap bit included).
  localparam int PTR_MAX_W = 16;

  function automatic logic [PTR_MAX_W-1:0] bin2gray(input logic [PTR_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_MAX_W-1:0] gray2bin(input logic [PTR_MAX_W-1:0] g);
    logic [PTR_MAX_W-1:0] b;
    b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
    for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dcf_sync2.sv
// Multi-stage synchronizer with asynchronous clear; also used as reset release.
module dcf_sync2 #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
// Storage array: written in the write domain, read combinationally by address.
module dcf_mem #(
  parameter int DW = 8,
  parameter int AW = 6,
  localparam int NWORDS = 1 << AW
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [NWORDS];

  always_ff @(posedge wr_clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-domain pointer, Gray publication and full/almost-full flags.
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW  = 6,
  parameter int GAP = 7,
  localparam int PW    = AW + 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [PW-1:0] rgray_sync,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] wr_gray,
  output logic          mem_we,
  output logic          full_n,
  output logic          afull_n
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] gray_q, gray_d;
  logic          full_n_q, full_n_d;
  logic          afull_n_q, afull_n_d;
  logic          wr_go;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] used_d;

  always_comb begin
    wr_go     = !wr_en_n && full_n_q;
    ptr_d     = ptr_q + PW'(wr_go);
    gray_d    = PW'(bin2gray(PTR_MAX_W'(ptr_d)));
    rbin_s    = PW'(gray2bin(PTR_MAX_W'(rgray_sync)));
    used_d    = ptr_d - rbin_s;
    full_n_d  = (used_d != PW'(DEPTH));
    afull_n_d = (used_d < PW'(DEPTH - GAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      gray_q    <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      ptr_q     <= ptr_d;
      gray_q    <= gray_d;
      full_n_q  <= full_n_d;
      afull_n_q <= afull_n_d;
    end
  end

  assign wr_ptr  = ptr_q;
  assign wr_gray = gray_q;
  assign mem_we  = wr_go;
  assign full_n  = full_n_q;
  assign afull_n = afull_n_q;

endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-domain pointer, output register and empty/almost-empty flags.
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AW  = 6,
  parameter int GAP = 7,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic [PW-1:0] wgray_sync,
  input  logic [DW-1:0] mem_rdata,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] rd_gray,
  output logic [DW-1:0] rd_q,
  output logic          empty_n,
  output logic          aempty_n
);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] gray_q, gray_d;
  logic [DW-1:0] q_q, q_d;
  logic          empty_n_q, empty_n_d;
  logic          aempty_n_q, aempty_n_d;
  logic          rd_go;
  logic [PW-1:0] wbin_s;
  logic [PW-1:0] avail_d;

  always_comb begin
    rd_go      = !rd_en_n && empty_n_q;
    ptr_d      = ptr_q + PW'(rd_go);
    gray_d     = PW'(bin2gray(PTR_MAX_W'(ptr_d)));
    q_d        = rd_go ? mem_rdata : q_q;
    wbin_s     = PW'(gray2bin(PTR_MAX_W'(wgray_sync)));
    avail_d    = wbin_s - ptr_d;
    empty_n_d  = (avail_d != '0);
    aempty_n_d = (avail_d > PW'(GAP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      gray_q     <= '0;
      q_q        <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      ptr_q      <= ptr_d;
      gray_q     <= gray_d;
      q_q        <= q_d;
      empty_n_q  <= empty_n_d;
      aempty_n_q <= aempty_n_d;
    end
  end

  assign rd_ptr   = ptr_q;
  assign rd_gray  = gray_q;
  assign rd_q     = q_q;
  assign empty_n  = empty_n_q;
  assign aempty_n = aempty_n_q;

endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DW          = 8,
  parameter int DEPTH       = 64,
  parameter int FLAG_GAP    = 7,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en_n,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rd_en_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          empty_n,
  output logic          aempty_n
);

  logic          wr_rst_n, rd_rst_n;
  logic [PW-1:0] wptr_bin, rptr_bin;
  logic [PW-1:0] wgray, rgray;
  logic [PW-1:0] wgray_rs, rgray_ws;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] rd_q_reg;

  // Reset: asserted asynchronously, released on each domain's own clock.
  dcf_sync2 #(.W(1), .STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n)
  );
  dcf_sync2 #(.W(1), .STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n)
  );

  // Gray pointer crossings.
  dcf_sync2 #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_ws)
  );
  dcf_sync2 #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rs)
  );

  dcf_wr_ctl #(.AW(AW), .GAP(FLAG_GAP)) u_wr (
    .clk       (wr_clk),
    .rst_n     (wr_rst_n),
    .wr_en_n   (wr_en_n),
    .rgray_sync(rgray_ws),
    .wr_ptr    (wptr_bin),
    .wr_gray   (wgray),
    .mem_we    (mem_we),
    .full_n    (full_n),
    .afull_n   (afull_n)
  );

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wr_clk(wr_clk),
    .we    (mem_we),
    .waddr (wptr_bin[AW-1:0]),
    .wdata (wr_data),
    .raddr (rptr_bin[AW-1:0]),
    .rdata (mem_rdata)
  );

  dcf_rd_ctl #(.DW(DW), .AW(AW), .GAP(FLAG_GAP)) u_rd (
    .clk       (rd_clk),
    .rst_n     (rd_rst_n),
    .rd_en_n   (rd_en_n),
    .wgray_sync(wgray_rs),
    .mem_rdata (mem_rdata),
    .rd_ptr    (rptr_bin),
    .rd_gray   (rgray),
    .rd_q      (rd_q_reg),
    .empty_n   (empty_n),
    .aempty_n  (aempty_n)
  );

  assign rd_data = out_en_n ? {DW{1'bz}} : rd_q_reg;

endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int PW    = 7
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          rd_en_n,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [DW-1:0] rd_q
);

  logic [PW-1:0] occ;
  assign occ = wptr - rptr;

  // R2: nothing is stored while full
  assert_no_overflow_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |=> $stable(wptr));

  // R3: nothing is consumed while empty
  assert_no_underflow_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |=> $stable(rptr));

  // R4: idle reads keep the output register
  assert_idle_hold_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_en_n |=> $stable(rd_q));

  // R8: never report data that is not there
  assert_no_phantom_data_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    empty_n |-> (occ != '0));

  // R8: never report space that is not there
  assert_no_phantom_space_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full_n |-> (occ != PW'(DEPTH)));

  // R8 / R7: full implies almost-full
  assert_full_has_afull_R7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);

  // R8 / R6: empty implies almost-empty
  assert_empty_has_aempty_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

endmodule

bind dcf_fifo dcf_fifo_chk #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_chk (
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .rst_n   (rst_n),
  .rd_en_n (rd_en_n),
  .full_n  (full_n),
  .afull_n (afull_n),
  .empty_n (empty_n),
  .aempty_n(aempty_n),
  .wptr    (wptr_bin),
  .rptr    (rptr_bin),
  .rd_q    (rd_q_reg)
);

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/1ps
module dcf_fifo_tb;

  localparam int DEPTH = 64;
  localparam int GAP   = 7;

  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       rst_n;
  logic [7:0] wr_data;
  logic       wr_en_n;
  logic       rd_en_n;
  logic       out_en_n;
  logic       full_n, afull_n, empty_n, aempty_n;
  wire  [7:0] q_bus;

  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;
  logic [7:0] mq[$];
  logic [7:0] last_q = 8'h00;
  int         r8_bad = 0;

  always #2.0 wr_clk = ~wr_clk;   // 250 MHz
  always #2.9 rd_clk = ~rd_clk;   // unrelated read clock

  // Undriven bus lines read as 1, which makes high impedance visible.
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (q_bus[i]);
  end

  dcf_fifo #(.DW(8), .DEPTH(DEPTH), .FLAG_GAP(GAP)) u_dut (
    .wr_clk  (wr_clk),
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .wr_data (wr_data),
    .wr_en_n (wr_en_n),
    .full_n  (full_n),
    .afull_n (afull_n),
    .rd_en_n (rd_en_n),
    .out_en_n(out_en_n),
    .rd_data (q_bus),
    .empty_n (empty_n),
    .aempty_n(aempty_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
  endtask

  task automatic check_flags(input string req);
    int cnt;
    cnt = mq.size();
    check({req, " empty_n"},  int'(empty_n),  int'(cnt != 0));
    check({req, " aempty_n"}, int'(aempty_n), int'(cnt > GAP));
    check({req, " full_n"},   int'(full_n),   int'(cnt != DEPTH));
    check({req, " afull_n"},  int'(afull_n),  int'(cnt < DEPTH - GAP));
  endtask

  task automatic push_words(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_data = base + 8'(i);
      wr_en_n = 1'b0;
      if (full_n) mq.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_en_n = 1'b1;
  endtask

  task automatic pop_one(input string req);
    logic       go;
    logic [7:0] exp;
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    go = empty_n;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
    if (go && mq.size() > 0) begin
      exp = mq.pop_front();
      last_q = exp;
      check(req, int'(q_bus), int'(exp));
    end else begin
      check("R3 read while empty", int'(q_bus), int'(last_q));
    end
  endtask

  // R1, R10
  task automatic t_reset();
    rst_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1; out_en_n = 1'b0; wr_data = 8'h00;
    repeat (5) @(negedge wr_clk);
    check("R1 empty_n in reset",  int'(empty_n),  0);
    check("R1 aempty_n in reset", int'(aempty_n), 0);
    check("R1 full_n in reset",   int'(full_n),   1);
    check("R1 afull_n in reset",  int'(afull_n),  1);
    check("R1 output register",   int'(q_bus),    8'h00);
    out_en_n = 1'b1;
    #1;
    check("R10 bus released", int'(q_bus), 8'hFF);
    out_en_n = 1'b0;
    #1;
    check("R10 bus driven", int'(q_bus), 8'h00);
    @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    check_flags("R1 after release");
  endtask

  // R6, R7, R2, R5, R3
  task automatic t_fill_drain();
    push_words(7, 8'h10);  settle(); check_flags("R6 7 words");
    push_words(1, 8'h17);  settle(); check_flags("R6 8 words");
    push_words(48, 8'h18); settle(); check_flags("R7 56 words");
    push_words(1, 8'h48);  settle(); check_flags("R7 57 words");
    push_words(6, 8'h49);  settle(); check_flags("R7 63 words");
    push_words(1, 8'h4F);  settle(); check_flags("R7 64 words");
    push_words(3, 8'hEE);  settle();
    check("R2 full after extra writes", int'(full_n), 0);
    check("R2 model depth", mq.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) pop_one("R5 drain order");
    pop_one("R3 empty read 1");
    pop_one("R3 empty read 2");
    settle();
    check_flags("R6 drained");
  endtask

  // R9
  task automatic t_first_word();
    int k;
    @(negedge wr_clk);
    wr_data = 8'hA5;
    wr_en_n = 1'b0;
    mq.push_back(8'hA5);
    @(posedge wr_clk);
    fork
      begin
        @(negedge wr_clk);
        wr_en_n = 1'b1;
      end
    join_none
    k = 0;
    do begin
      @(posedge rd_clk);
      @(negedge rd_clk);
      k++;
    end while (!empty_n && k < 10);
    check("R9 empty_n rise within 4 read edges", int'(k <= 4), 1);
    check("R9 empty_n rose", int'(empty_n), 1);
    pop_one("R5 first word");
  endtask

  // R4, R10
  task automatic t_hold();
    push_words(1, 8'h3C);
    push_words(1, 8'hC3);
    settle();
    pop_one("R5 hold setup");
    repeat (10) @(negedge rd_clk);
    check("R4 register held while idle", int'(q_bus), 8'h3C);
    out_en_n = 1'b1;
    #1;
    check("R10 bus high impedance", int'(q_bus), 8'hFF);
    repeat (3) @(negedge rd_clk);
    out_en_n = 1'b0;
    #1;
    check("R10 bus driven again", int'(q_bus), 8'h3C);
    check("R4 register held under disable", int'(q_bus), 8'h3C);
    pop_one("R5 hold second word");
  endtask

  // R5, R8, R2, R3 under concurrent traffic
  task automatic t_stream(input int n, input int wthr, input int rthr, input logic [15:0] seed);
    fork
      begin : writer
        logic [15:0] lf;
        logic [7:0]  seq;
        int          sent;
        lf = seed; seq = 8'h00; sent = 0;
        while (sent < n) begin
          @(negedge wr_clk);
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (int'(lf[2:0]) < wthr) begin
            wr_en_n = 1'b0;
            wr_data = seq;
            if (full_n) begin
              mq.push_back(seq);
              seq++;
              sent++;
            end
          end else begin
            wr_en_n = 1'b1;
          end
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
      end
      begin : reader
        logic [15:0] lf;
        logic [7:0]  exp;
        int          got;
        bit          pend;
        lf = ~seed; got = 0; pend = 1'b0;
        while (got < n || pend) begin
          @(negedge rd_clk);
          if (pend) begin
            exp = mq.pop_front();
            last_q = exp;
            check("R5 stream order", int'(q_bus), int'(exp));
            pend = 1'b0;
          end
          if (empty_n && mq.size() == 0) r8_bad++;
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (got < n && int'(lf[2:0]) < rthr) begin
            rd_en_n = 1'b0;
            pend = empty_n;
            if (empty_n) got++;
          end else begin
            rd_en_n = 1'b1;
          end
        end
        rd_en_n = 1'b1;
      end
    join
    settle();
    check_flags("R6 after stream");
  endtask

  initial begin
    t_reset();
    t_fill_drain();
    t_first_word();
    t_hold();
    t_stream(300, 7, 3, 16'hACE1);
    t_stream(300, 2, 8, 16'h1D2B);
    check("R8 data flag never optimistic", r8_bad, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge wr_clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule